// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit device virtual address into a physical address by reading a two-level table held in memory. A requester offers an address, an access direction and a 5-bit requester tag. The walker fetches a first-level entry, located from a directory base input, and then a second-level entry. It checks the present and permission bits and returns either the translated address or a fault record.

Only one walk runs at a time, and the memory side never has more than one read outstanding. A walk that hits a missing entry, a missing permission or a failed memory read ends in a fault. The fault record stays on the outputs until the requester acknowledges it, and no new request is taken before then. Caching of translations and pages larger than 4 KiB are not supported. Every page is 4 KiB and every table holds 1024 four-byte entries.

Top module: `xlate_walker`

## Requirements
- R1: After reset `req_ready` is 1, while `rsp_valid`, `flt_valid` and `mem_rd_valid` are 0.
- R2: The first read of a walk goes to `dir_base` plus 4 times virtual address bits 31:22. `dir_base` is sampled when the request is accepted.
- R3: The second read goes to the first-level entry with bit 0 cleared, plus 4 times virtual address bits 21:12.
- R4: A successful walk raises `rsp_valid` for one cycle. `rsp_paddr` then carries second-level entry bits 31:12 joined with virtual address bits 11:0, and `rsp_id` echoes the request tag.
- R5: A first-level entry with bit 0 (present) clear ends the walk as a page fault (`flt_bus` = 0) without a second read. `flt_vaddr`, `flt_write` and `flt_id` report the request.
- R6: A second-level entry with bit 0 (present) clear ends the walk as a page fault.
- R7: A read whose second-level entry has bit 1 clear, or a write whose entry has bit 2 clear, is a page fault. A write does not need bit 1 and a read does not need bit 2.
- R8: `mem_rsp_err` on either read ends the walk with `flt_bus` = 1, which marks a bus error rather than a page fault.
- R9: Walks do not overlap. `req_ready` is low from acceptance until the walk ends, at most one memory read is outstanding, and `rsp_valid` and `flt_valid` are never high together.
- R10: `flt_valid` and its fields hold until `flt_ack`. While `flt_valid` is high `req_ready` is 0, and one cycle with `flt_ack` high clears the fault.
- R11: While `mem_rd_valid` is high and `mem_rd_ready` is low, the read request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_id | input | 5 | Requester tag |
| dir_base | input | 32 | First-level table base address |
| rsp_valid | output | 1 | One-cycle pulse: translation done |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_id | output | 5 | Tag of the completed request |
| flt_valid | output | 1 | Fault pending |
| flt_bus | output | 1 | 1 = bus error, 0 = page fault |
| flt_vaddr | output | 32 | Faulting virtual address |
| flt_write | output | 1 | Direction of the faulting access |
| flt_id | output | 5 | Tag of the faulting request |
| flt_ack | input | 1 | Clears the pending fault |
| mem_rd_valid | output | 1 | Table read request |
| mem_rd_ready | input | 1 | Memory takes the read |
| mem_rd_addr | output | 32 | Table entry address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry value |
| mem_rsp_err | input | 1 | Read failed |

## Verification
The assertions assume that memory returns exactly one `mem_rsp_valid` beat for each accepted read and never one unprompted. They also assume that the requester raises `flt_ack` only while a fault is pending. The bench's memory model answers each accepted read once, after a variable delay, and holds `mem_rd_ready` low while an answer is due. Its acknowledge comes from the monitor, and only after a fault has been observed and held for a few cycles. Randomized ready stalls exercise the held read request.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  localparam int ADDR_W = 32;
  localparam int IDX_W  = 10;
  localparam int OFS_W  = 12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT
  } walk_state_e;

  function automatic logic [ADDR_W-1:0] l1_entry_addr(
      input logic [ADDR_W-1:0] base, input logic [ADDR_W-1:0] va);
    l1_entry_addr = base + {{(ADDR_W-IDX_W-2){1'b0}}, va[ADDR_W-1 -: IDX_W], 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] l2_entry_addr(
      input logic [ADDR_W-1:0] l1e, input logic [ADDR_W-1:0] va);
    l2_entry_addr = {l1e[ADDR_W-1:1], 1'b0}
                  + {{(ADDR_W-IDX_W-2){1'b0}}, va[OFS_W +: IDX_W], 2'b00};
  endfunction

  function automatic logic pte_grants(input logic [ADDR_W-1:0] pte, input logic wr);
    pte_grants = pte[0] && (wr ? pte[2] : pte[1]);
  endfunction

  function automatic logic [ADDR_W-1:0] join_phys(
      input logic [ADDR_W-1:0] pte, input logic [ADDR_W-1:0] va);
    join_phys = {pte[ADDR_W-1:OFS_W], va[OFS_W-1:0]};
  endfunction
endpackage

// File: rtl/xlate_walk_ctrl.sv
module xlate_walk_ctrl
  import xlate_pkg::*;
#(
  parameter int ID_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] dir_base,
  input  logic              fault_pending,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err,
  output logic              ev_fault,
  output logic              ev_fault_bus,
  output logic [ADDR_W-1:0] cur_vaddr,
  output logic              cur_write,
  output logic [ID_W-1:0]   cur_id,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ID_W-1:0]   rsp_id
);
  walk_state_e       state;
  logic [ADDR_W-1:0] va_q, base_q, l1e_q;
  logic              wr_q;
  logic [ID_W-1:0]   id_q;

  logic accept, l1_beat, l2_beat, l1_miss, l2_deny, bus_hit, walk_ok;

  assign req_ready    = (state == ST_IDLE) && !fault_pending;
  assign accept       = req_valid && req_ready;
  assign l1_beat      = (state == ST_L1_WAIT) && mem_rsp_valid;
  assign l2_beat      = (state == ST_L2_WAIT) && mem_rsp_valid;
  assign bus_hit      = (l1_beat || l2_beat) && mem_rsp_err;
  assign l1_miss      = l1_beat && !mem_rsp_err && !mem_rsp_data[0];
  assign l2_deny      = l2_beat && !mem_rsp_err && !pte_grants(mem_rsp_data, wr_q);
  assign walk_ok      = l2_beat && !mem_rsp_err && pte_grants(mem_rsp_data, wr_q);
  assign ev_fault     = bus_hit || l1_miss || l2_deny;
  assign ev_fault_bus = bus_hit;

  assign mem_rd_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
  assign mem_rd_addr  = (state == ST_L2_REQ) ? l2_entry_addr(l1e_q, va_q)
                                             : l1_entry_addr(base_q, va_q);
  assign cur_vaddr = va_q;
  assign cur_write = wr_q;
  assign cur_id    = id_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      base_q    <= '0;
      l1e_q     <= '0;
      wr_q      <= 1'b0;
      id_q      <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_id    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          va_q   <= req_vaddr;
          base_q <= dir_base;
          wr_q   <= req_write;
          id_q   <= req_id;
          state  <= ST_L1_REQ;
        end
        ST_L1_REQ: if (mem_rd_ready) state <= ST_L1_WAIT;
        ST_L1_WAIT: if (mem_rsp_valid) begin
          l1e_q <= mem_rsp_data;
          state <= ev_fault ? ST_IDLE : ST_L2_REQ;
        end
        ST_L2_REQ: if (mem_rd_ready) state <= ST_L2_WAIT;
        ST_L2_WAIT: if (mem_rsp_valid) begin
          state <= ST_IDLE;
          if (walk_ok) begin
            rsp_valid <= 1'b1;
            rsp_paddr <= join_phys(mem_rsp_data, va_q);
            rsp_id    <= id_q;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ONE_READ_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && mem_rd_ready |=> !mem_rd_valid);                    // R9
  AST_RD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr)); // R11
  AST_L1_MISS_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    l1_miss |=> !mem_rd_valid);                                         // R5
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_paddr[OFS_W-1:0] == va_q[OFS_W-1:0]);            // R4
endmodule

// File: rtl/xlate_fault_hold.sv
module xlate_fault_hold
  import xlate_pkg::*;
#(
  parameter int ID_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_fault,
  input  logic              ev_fault_bus,
  input  logic [ADDR_W-1:0] cur_vaddr,
  input  logic              cur_write,
  input  logic [ID_W-1:0]   cur_id,
  input  logic              flt_ack,
  output logic              flt_valid,
  output logic              flt_bus,
  output logic [ADDR_W-1:0] flt_vaddr,
  output logic              flt_write,
  output logic [ID_W-1:0]   flt_id
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_valid <= 1'b0;
      flt_bus   <= 1'b0;
      flt_vaddr <= '0;
      flt_write <= 1'b0;
      flt_id    <= '0;
    end else if (ev_fault) begin
      flt_valid <= 1'b1;
      flt_bus   <= ev_fault_bus;
      flt_vaddr <= cur_vaddr;
      flt_write <= cur_write;
      flt_id    <= cur_id;
    end else if (flt_ack) begin
      flt_valid <= 1'b0;
    end
  end

  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid && !flt_ack |=> flt_valid && $stable(flt_vaddr) && $stable(flt_id)); // R10
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
  import xlate_pkg::*;
#(
  parameter int ID_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] dir_base,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ID_W-1:0]   rsp_id,
  output logic              flt_valid,
  output logic              flt_bus,
  output logic [ADDR_W-1:0] flt_vaddr,
  output logic              flt_write,
  output logic [ID_W-1:0]   flt_id,
  input  logic              flt_ack,
  output logic              mem_rd_valid,
  input  logic              mem_rd_ready,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data,
  input  logic              mem_rsp_err
);
  logic              ev_fault, ev_fault_bus, cur_write;
  logic [ADDR_W-1:0] cur_vaddr;
  logic [ID_W-1:0]   cur_id;

  xlate_walk_ctrl #(.ID_W(ID_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_id(req_id), .dir_base(dir_base),
    .fault_pending(flt_valid),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
    .ev_fault(ev_fault), .ev_fault_bus(ev_fault_bus),
    .cur_vaddr(cur_vaddr), .cur_write(cur_write), .cur_id(cur_id),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_id(rsp_id)
  );

  xlate_fault_hold #(.ID_W(ID_W)) u_fault (
    .clk(clk), .rst_n(rst_n),
    .ev_fault(ev_fault), .ev_fault_bus(ev_fault_bus),
    .cur_vaddr(cur_vaddr), .cur_write(cur_write), .cur_id(cur_id),
    .flt_ack(flt_ack),
    .flt_valid(flt_valid), .flt_bus(flt_bus), .flt_vaddr(flt_vaddr),
    .flt_write(flt_write), .flt_id(flt_id)
  );

  AST_FAULT_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    flt_valid |-> !req_ready);                                          // R10
  AST_RSP_FLT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_valid && flt_valid));                                         // R9
endmodule

// File: tb/tb_xlate_walker.sv
module tb_xlate_walker;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0, flt_ack = 0;
  logic [31:0] req_vaddr = 0, dir_base = 0;
  logic [4:0]  req_id = 0;
  logic        req_ready, rsp_valid, flt_valid, flt_bus, flt_write;
  logic [31:0] rsp_paddr, flt_vaddr, mem_rd_addr;
  logic [4:0]  rsp_id, flt_id;
  logic        mem_rd_valid, mem_rd_ready = 0, mem_rsp_valid = 0, mem_rsp_err = 0;
  logic [31:0] mem_rsp_data = 0;

  always #10 clk = ~clk;

  xlate_walker dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .req_id(req_id), .dir_base(dir_base),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_id(rsp_id),
    .flt_valid(flt_valid), .flt_bus(flt_bus), .flt_vaddr(flt_vaddr),
    .flt_write(flt_write), .flt_id(flt_id), .flt_ack(flt_ack),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err)
  );

  typedef struct {
    bit          flt;
    bit          bus;
    logic [31:0] val;
    bit          wr;
    logic [4:0]  id;
    string       tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];
  bit [31:0]   mem_tbl[bit [31:0]];
  bit          err_tbl[bit [31:0]];
  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] rd(input bit [31:0] a);
    return mem_tbl.exists(a) ? mem_tbl[a] : 32'h0;
  endfunction

  function automatic logic [31:0] va(input int l1, input int l2, input int off);
    return {l1[9:0], l2[9:0], off[11:0]};
  endfunction

  // Driver: model the walk independently, queue expected reads and result, then offer it.
  task automatic walk(input logic [31:0] base, input logic [31:0] v, input bit wr,
                      input logic [4:0] id, input string tag);
    exp_t e;
    bit [31:0] a1, a2, e1, e2;
    bit ok;
    e.tag = tag; e.wr = wr; e.id = id; e.bus = 0; e.flt = 1; e.val = v;
    a1 = base + 32'(v[31:22]) * 4;
    addr_q.push_back(a1);
    if (err_tbl.exists(a1)) e.bus = 1;
    else begin
      e1 = rd(a1);
      if (e1[0]) begin
        a2 = (e1 & 32'hFFFF_FFFE) + 32'(v[21:12]) * 4;
        addr_q.push_back(a2);
        if (err_tbl.exists(a2)) e.bus = 1;
        else begin
          e2 = rd(a2);
          ok = e2[0] && (wr ? e2[2] : e2[1]);
          if (ok) begin e.flt = 0; e.val = {e2[31:12], v[11:0]}; end
        end
      end
    end
    exp_q.push_back(e);
    @(negedge clk);
    dir_base = base; req_vaddr = v; req_write = wr; req_id = id; req_valid = 1;
    forever begin
      if (req_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  // Memory model: random ready stalls, one response per accepted read, variable delay.
  initial begin
    logic [31:0] a;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 0; mem_rsp_err = 0;
      mem_rd_ready = ($urandom % 3) != 0;
      if (mem_rd_valid && mem_rd_ready) begin
        a = mem_rd_addr;
        if (addr_q.size() == 0) chk("R9 unexpected table read", a, 32'hDEAD_BEEF);
        else chk("R2 R3 table read address", a, addr_q.pop_front());
        @(negedge clk);
        mem_rd_ready = 0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rsp_valid = 1;
        mem_rsp_err   = err_tbl.exists(a);
        mem_rsp_data  = rd(a);
      end
    end
  end

  // Monitor: pop expected items and compare with results as they appear.
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && rsp_valid) begin
        if (exp_q.size() == 0) chk("R9 unexpected response", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk({e.tag, " fault flag"}, 0, {31'd0, e.flt});
          chk({e.tag, " paddr R4"}, rsp_paddr, e.val);
          chk({e.tag, " rsp id R4"}, {27'd0, rsp_id}, {27'd0, e.id});
        end
      end
      if (rst_n && flt_valid) begin
        if (exp_q.size() == 0) chk("R9 unexpected fault", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk({e.tag, " fault flag"}, 1, {31'd0, e.flt});
          chk({e.tag, " cause bus R8"}, {31'd0, flt_bus}, {31'd0, e.bus});
          chk({e.tag, " fault vaddr"}, flt_vaddr, e.val);
          chk({e.tag, " fault write"}, {31'd0, flt_write}, {31'd0, e.wr});
          chk({e.tag, " fault id"}, {27'd0, flt_id}, {27'd0, e.id});
        end
        chk("R10 no accept while fault", {31'd0, req_ready}, 0);
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk("R10 fault held", {31'd0, flt_valid}, 1);
          chk("R10 ready low while fault", {31'd0, req_ready}, 0);
        end
        flt_ack = 1;
        @(negedge clk);
        flt_ack = 0;
        chk("R10 fault cleared by ack", {31'd0, flt_valid}, 0);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    // Tables: dir 0x0010_0000 and 0x0040_0000; level-2 tables at 0x0020_0000 and 0x0030_0000.
    mem_tbl[32'h0010_0004] = 32'h0020_0001;
    mem_tbl[32'h0010_0008] = 32'h0000_0000;
    err_tbl[32'h0010_000C] = 1;
    mem_tbl[32'h0010_0FFC] = 32'h0030_0001;
    mem_tbl[32'h0040_0004] = 32'h0030_0001;
    mem_tbl[32'h0020_0014] = 32'hABCD_E007;
    mem_tbl[32'h0020_0018] = 32'h1234_5003;
    mem_tbl[32'h0020_001C] = 32'h5555_5005;
    mem_tbl[32'h0020_0020] = 32'h7777_7006;
    err_tbl[32'h0020_0024] = 1;
    mem_tbl[32'h0030_0FFC] = 32'hFFFF_F007;
    mem_tbl[32'h0030_0004] = 32'h0BAD_0003;

    repeat (3) @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 1);
    chk("R1 reset rsp", {31'd0, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle flt", {31'd0, flt_valid}, 0);
    chk("R1 idle mem rd", {31'd0, mem_rd_valid}, 0);
    chk("R1 idle ready", {31'd0, req_ready}, 1);

    walk(32'h0010_0000, va(1, 5, 'h123), 0, 5'd3,  "R4 read ok");
    walk(32'h0010_0000, va(1, 5, 'hFFF), 1, 5'd31, "R4 write ok");
    walk(32'h0010_0000, va(1, 6, 'h010), 1, 5'd7,  "R7 write to read-only");
    walk(32'h0010_0000, va(1, 6, 'h020), 0, 5'd8,  "R7 read of read-only");
    walk(32'h0010_0000, va(1, 7, 'h030), 0, 5'd9,  "R7 read of write-only");
    walk(32'h0010_0000, va(1, 7, 'h040), 1, 5'd10, "R7 write of write-only");
    walk(32'h0010_0000, va(1, 8, 'h050), 0, 5'd11, "R6 level-2 absent");
    walk(32'h0010_0000, va(2, 4, 'h060), 1, 5'd12, "R5 level-1 absent");
    walk(32'h0010_0000, va(3, 4, 'h070), 1, 5'd13, "R8 level-1 bus error");
    walk(32'h0010_0000, va(1, 9, 'h080), 0, 5'd14, "R8 level-2 bus error");
    walk(32'h0010_0000, va(1023, 1023, 'hABC), 1, 5'd0, "R3 top indices");
    walk(32'h0040_0000, va(1, 1, 'h5A5), 0, 5'd21, "R2 other directory");
    walk(32'h0010_0000, va(1, 5, 'h000), 0, 5'd1,  "R9 back-to-back");
    @(negedge clk);
    req_valid = 0;

    for (int w = 0; w < 400 && (exp_q.size() != 0 || addr_q.size() != 0); w++)
      @(negedge clk);
    chk("R9 all results seen", exp_q.size(), 0);
    chk("R5 R9 no missing reads", addr_q.size(), 0);
    repeat (4) @(negedge clk);
    summary();
  end
endmodule